// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a narrow host bus reach a large internal register space through three host-visible registers: a command word, a data holding register and a status register. The host writes a command carrying a start flag, a direction bit, two address-stepping flags and a 16-bit target address. It then polls the start flag, which stays set as "busy" until the internal access has completed. Read results are placed in the holding register. Write data is taken from the holding register.

When one of the stepping flags is set, the host can stream through consecutive addresses without writing the command again. In read mode, each host read of the holding register moves the stored address by one and fetches the next word. In write mode, each host write of the holding register moves the address and stores the new word. The upper half of the host address space is a direct window. A host write there sends the word straight to a fixed base address plus the window offset.

Internally the bridge drives a request/acknowledge register bus. The request is held with a stable address until the target acknowledges, which may take any number of cycles. Host writes that arrive while an access is in flight are dropped, and a sticky error flag records each drop.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset the internal request is low, and the command word (host offset 0), the holding register (offset 1) and the status register (offset 2) all read as zero.
- R2: A host write to offset 0 with bit 31 set starts an internal access to address bits 15:0. Bit 30 selects the direction, 1 for a read. The request rises in the cycle after the write and stays high, with stable address and direction, until acknowledge.
- R3: Command bit 31 reads 1 from the cycle after a start until the acknowledge edge, and reads 0 from the cycle after the acknowledge is sampled.
- R4: After a read access completes, offset 1 returns the internal read data. With both stepping flags clear, reading offset 1 starts no access.
- R5: A write access drives the holding register value on the write-data output, with the write enable high, to the command address.
- R6: With bit 30 set and a stepping flag set, a host read of offset 1 while idle moves the stored address by one and starts the next read. Clearing both flags before the last read leaves that read without a follow-up access.
- R7: With bit 30 clear and a stepping flag set, a host write of offset 1 while idle stores the word, moves the address by one and starts a write of that word to the new address.
- R8: Bit 29 steps the address up and bit 28 steps it down. Bit 29 wins when both are set. The address wraps modulo 2^16.
- R9: A host write to an offset with host address bit 7 set starts a write of that word to base 0x0400 plus address bits 6:0. The write also loads the holding register and leaves the command address unchanged.
- R10: Host writes to offset 0, offset 1 or the window while busy are dropped and set status bit 0. Writing 1 to status bit 0 clears it.
- R11: Command bits 29:28 read back the stepping flags, and bits 27:16 read as zero.
- R12: A host write to offset 0 with bit 31 clear updates the direction, flags and address but starts no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_addr_i | input | 8 | Host register offset |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read strobe |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Host read data, valid in the strobe cycle |
| ireq_o | output | 1 | Internal access request |
| iwe_o | output | 1 | Internal access is a write |
| iaddr_o | output | 16 | Internal target address |
| iwdata_o | output | 32 | Internal write data |
| iack_i | input | 1 | Internal acknowledge |
| irdata_i | input | 32 | Internal read data, valid with acknowledge |

## Verification
Two events can land on the same clock edge: a host register write and the internal acknowledge that ends the access. The bench uses a known target latency to time a command write onto exactly the edge where the acknowledge is sampled. It then expects that write to be dropped with the error flag set, and busy to read clear in the very next cycle. Host reads of the holding register issued while busy are also checked: they must not advance a streaming sequence.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  localparam int HOST_DW = 32;
  localparam int TADDR_W = 16;
  localparam int GO_B    = 31;
  localparam int RNW_B   = 30;
  localparam int INC_B   = 29;
  localparam int DEC_B   = 28;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_CMD,
    ACC_DATA,
    ACC_STAT,
    ACC_WIN
  } acc_e;

  function automatic logic [TADDR_W-1:0] step_addr(input logic [TADDR_W-1:0] a,
                                                   input logic inc, input logic dec);
    if (inc)      step_addr = a + 1'b1;
    else if (dec) step_addr = a - 1'b1;
    else          step_addr = a;
  endfunction
endpackage

// File: rtl/ibr_decode.sv
module ibr_decode
  import ibr_pkg::*;
#(
  parameter int              HOST_AW  = 8,
  parameter logic [15:0]     WIN_BASE = 16'h0400
) (
  input  logic [HOST_AW-1:0] addr_i,
  output acc_e               kind_o,
  output logic [TADDR_W-1:0] win_addr_o
);
  localparam int OFF_W = HOST_AW - 1;

  logic [OFF_W-1:0] off;
  assign off        = addr_i[OFF_W-1:0];
  assign win_addr_o = WIN_BASE + TADDR_W'(off);

  always_comb begin
    if (addr_i[HOST_AW-1])             kind_o = ACC_WIN;
    else if (off == OFF_W'(0))         kind_o = ACC_CMD;
    else if (off == OFF_W'(1))         kind_o = ACC_DATA;
    else if (off == OFF_W'(2))         kind_o = ACC_STAT;
    else                               kind_o = ACC_NONE;
  end
endmodule

// File: rtl/ibr_regs.sv
module ibr_regs
  import ibr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  acc_e               kind_i,
  input  logic [TADDR_W-1:0] win_addr_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [HOST_DW-1:0] wdata_i,
  input  logic               busy_i,
  input  logic               rd_done_i,
  input  logic [HOST_DW-1:0] rd_data_i,
  output logic               start_o,
  output logic               start_we_o,
  output logic [TADDR_W-1:0] start_addr_o,
  output logic [HOST_DW-1:0] start_wdata_o,
  output logic               rnw_o,
  output logic               inc_o,
  output logic               dec_o,
  output logic [TADDR_W-1:0] addr_o,
  output logic [HOST_DW-1:0] data_o,
  output logic               err_o
);
  logic               rnw_q, inc_q, dec_q, err_q;
  logic [TADDR_W-1:0] addr_q;
  logic [HOST_DW-1:0] data_q;
  logic wr_cmd, wr_data, wr_win, wr_stat, rd_data;
  logic blocked, auto_on, cmd_go, data_go, rd_go, win_go;
  logic [TADDR_W-1:0] next_addr;

  assign wr_cmd  = wr_i && (kind_i == ACC_CMD);
  assign wr_data = wr_i && (kind_i == ACC_DATA);
  assign wr_win  = wr_i && (kind_i == ACC_WIN);
  assign wr_stat = wr_i && (kind_i == ACC_STAT);
  assign rd_data = rd_i && !wr_i && (kind_i == ACC_DATA);

  assign blocked   = busy_i && (wr_cmd || wr_data || wr_win);
  assign auto_on   = inc_q || dec_q;
  assign next_addr = step_addr(addr_q, inc_q, dec_q);

  assign cmd_go  = wr_cmd  && !busy_i && wdata_i[GO_B];
  assign data_go = wr_data && !busy_i && auto_on && !rnw_q;
  assign rd_go   = rd_data && !busy_i && auto_on && rnw_q;
  assign win_go  = wr_win  && !busy_i;

  assign start_o = cmd_go || data_go || rd_go || win_go;

  always_comb begin
    start_we_o    = 1'b0;
    start_addr_o  = next_addr;
    start_wdata_o = wdata_i;
    if (cmd_go) begin
      start_we_o    = !wdata_i[RNW_B];
      start_addr_o  = wdata_i[TADDR_W-1:0];
      start_wdata_o = data_q;
    end else if (win_go) begin
      start_we_o   = 1'b1;
      start_addr_o = win_addr_i;
    end else if (data_go) begin
      start_we_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rnw_q  <= 1'b0;
      inc_q  <= 1'b0;
      dec_q  <= 1'b0;
      addr_q <= '0;
    end else if (wr_cmd && !busy_i) begin
      rnw_q  <= wdata_i[RNW_B];
      inc_q  <= wdata_i[INC_B];
      dec_q  <= wdata_i[DEC_B];
      addr_q <= wdata_i[TADDR_W-1:0];
    end else if (data_go || rd_go) begin
      addr_q <= next_addr;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              data_q <= '0;
    else if (rd_done_i)                       data_q <= rd_data_i;
    else if ((wr_data || wr_win) && !busy_i)  data_q <= wdata_i;
  end

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     err_q <= 1'b0;
    else if (blocked)                err_q <= 1'b1;
    else if (wr_stat && wdata_i[0])  err_q <= 1'b0;
  end

  assign rnw_o  = rnw_q;
  assign inc_o  = inc_q;
  assign dec_o  = dec_q;
  assign addr_o = addr_q;
  assign data_o = data_q;
  assign err_o  = err_q;

  p_drop_flags_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blocked |=> err_q);
  p_drop_keeps_cmd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && wr_cmd) |=> $stable(addr_q) && $stable(rnw_q));
  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !wr_stat) |=> err_q);
  p_stream_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_go |=> (addr_q == step_addr($past(addr_q), $past(inc_q), $past(dec_q))));
endmodule

// File: rtl/ibr_seq.sv
module ibr_seq
  import ibr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               start_we_i,
  input  logic [TADDR_W-1:0] start_addr_i,
  input  logic [HOST_DW-1:0] start_wdata_i,
  input  logic               iack_i,
  input  logic [HOST_DW-1:0] irdata_i,
  output logic               busy_o,
  output logic               ireq_o,
  output logic               iwe_o,
  output logic [TADDR_W-1:0] iaddr_o,
  output logic [HOST_DW-1:0] iwdata_o,
  output logic               rd_done_o,
  output logic [HOST_DW-1:0] rd_data_o
);
  logic               busy_q, we_q;
  logic [TADDR_W-1:0] addr_q;
  logic [HOST_DW-1:0] wdata_q;
  logic               done;

  assign done = busy_q && iack_i;

  // request and busy are one flop: busy clears the cycle after ack
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      busy_q <= 1'b0;
    else if (start_i) busy_q <= 1'b1;
    else if (done)    busy_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start_i) begin
      we_q    <= start_we_i;
      addr_q  <= start_addr_i;
      wdata_q <= start_wdata_i;
    end
  end

  assign busy_o    = busy_q;
  assign ireq_o    = busy_q;
  assign iwe_o     = we_q;
  assign iaddr_o   = addr_q;
  assign iwdata_o  = wdata_q;
  assign rd_done_o = done && !we_q;
  assign rd_data_o = irdata_i;

  p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !iack_i) |=> busy_q && $stable(addr_q) && $stable(we_q));
  p_start_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_q);
  p_ack_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !busy_q);
  p_no_start_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !start_i);
endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
  import ibr_pkg::*;
#(
  parameter int          HOST_AW  = 8,
  parameter logic [15:0] WIN_BASE = 16'h0400
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [HOST_AW-1:0] host_addr_i,
  input  logic               host_wr_i,
  input  logic               host_rd_i,
  input  logic [HOST_DW-1:0] host_wdata_i,
  output logic [HOST_DW-1:0] host_rdata_o,
  output logic               ireq_o,
  output logic               iwe_o,
  output logic [TADDR_W-1:0] iaddr_o,
  output logic [HOST_DW-1:0] iwdata_o,
  input  logic               iack_i,
  input  logic [HOST_DW-1:0] irdata_i
);
  localparam int RSV_W = INC_B - TADDR_W - 1;

  acc_e               kind;
  logic [TADDR_W-1:0] win_addr, start_addr, cmd_addr;
  logic [HOST_DW-1:0] start_wdata, data_q, rd_data;
  logic start, start_we, busy, rd_done, rnw, inc, dec, err;

  ibr_decode #(.HOST_AW(HOST_AW), .WIN_BASE(WIN_BASE)) u_decode (
    .addr_i     (host_addr_i),
    .kind_o     (kind),
    .win_addr_o (win_addr)
  );

  ibr_regs u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .kind_i        (kind),
    .win_addr_i    (win_addr),
    .wr_i          (host_wr_i),
    .rd_i          (host_rd_i),
    .wdata_i       (host_wdata_i),
    .busy_i        (busy),
    .rd_done_i     (rd_done),
    .rd_data_i     (rd_data),
    .start_o       (start),
    .start_we_o    (start_we),
    .start_addr_o  (start_addr),
    .start_wdata_o (start_wdata),
    .rnw_o         (rnw),
    .inc_o         (inc),
    .dec_o         (dec),
    .addr_o        (cmd_addr),
    .data_o        (data_q),
    .err_o         (err)
  );

  ibr_seq u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start),
    .start_we_i    (start_we),
    .start_addr_i  (start_addr),
    .start_wdata_i (start_wdata),
    .iack_i        (iack_i),
    .irdata_i      (irdata_i),
    .busy_o        (busy),
    .ireq_o        (ireq_o),
    .iwe_o         (iwe_o),
    .iaddr_o       (iaddr_o),
    .iwdata_o      (iwdata_o),
    .rd_done_o     (rd_done),
    .rd_data_o     (rd_data)
  );

  always_comb begin
    unique case (kind)
      ACC_CMD:  host_rdata_o = {busy, rnw, inc, dec, {RSV_W{1'b0}}, cmd_addr};
      ACC_DATA: host_rdata_o = data_q;
      ACC_STAT: host_rdata_o = {{(HOST_DW-1){1'b0}}, err};
      default:  host_rdata_o = '0;
    endcase
  end

  p_busy_is_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == ACC_CMD) |-> (host_rdata_o[GO_B] == ireq_o));
endmodule

// File: tb/ind_reg_bridge_bench.sv
module ind_reg_bridge_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CMD = 8'h00, A_DATA = 8'h01, A_STAT = 8'h02;
  localparam logic [15:0] WBASE = 16'h0400;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  haddr = '0;
  logic        hwr = 1'b0, hrd = 1'b0;
  logic [31:0] hwdata = '0, hrdata;
  logic        ireq, iwe, iack;
  logic [15:0] iaddr;
  logic [31:0] iwdata, irdata;

  int checks = 0, errors = 0;
  bit done = 0;
  int lat = 0, cnt = 0;
  int w_cnt = 0, r_cnt = 0;
  logic [15:0] w_addr;
  logic [31:0] w_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  ind_reg_bridge u_ind_reg_bridge (
    .clk_i(clk), .rst_ni(rst_n), .host_addr_i(haddr), .host_wr_i(hwr),
    .host_rd_i(hrd), .host_wdata_i(hwdata), .host_rdata_o(hrdata),
    .ireq_o(ireq), .iwe_o(iwe), .iaddr_o(iaddr), .iwdata_o(iwdata),
    .iack_i(iack), .irdata_i(irdata)
  );

  function automatic logic [31:0] model_rd(input logic [15:0] a);
    return {a ^ 16'h3C5A, ~a};
  endfunction

  function automatic logic [15:0] step(input logic [15:0] a, input bit inc, input bit dec);
    if (inc) return a + 16'd1;
    if (dec) return a - 16'd1;
    return a;
  endfunction

  function automatic logic [31:0] mk(input bit go, input bit rnw, input bit inc,
                                    input bit dec, input logic [15:0] a);
    return {go, rnw, inc, dec, 12'h000, a};
  endfunction

  // target model with programmable latency
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iack <= 1'b0; irdata <= '0; cnt <= 0;
    end else if (iack) begin
      iack <= 1'b0;
    end else if (ireq) begin
      if (cnt >= lat) begin
        iack <= 1'b1; cnt <= 0;
        if (iwe) begin w_addr <= iaddr; w_data <= iwdata; w_cnt <= w_cnt + 1; end
        else begin irdata <= model_rd(iaddr); r_cnt <= r_cnt + 1; end
      end else cnt <= cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); haddr = a; hwdata = d; hwr = 1'b1;
    @(negedge clk); hwr = 1'b0;
  endtask

  task automatic hread(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); haddr = a; hrd = 1'b1; #1 d = hrdata;
    @(negedge clk); hrd = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] v;
    int n = 0;
    do begin hread(A_CMD, v); n++; end while (v[31] && n < 200);
    check(!v[31], req, "busy never cleared", v, 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=0 exp=1");
    finish_run();
  end

  initial begin
    logic [31:0] v, d;
    logic [15:0] a, cur;
    int rc, wc;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(ireq == 1'b0, "R1", "ireq after reset", 32'(ireq), 32'h0);
    hread(A_CMD, v);  check(v == 0, "R1", "cmd after reset", v, 0);
    hread(A_DATA, v); check(v == 0, "R1", "data after reset", v, 0);
    hread(A_STAT, v); check(v == 0, "R1", "status after reset", v, 0);

    // R2/R3/R4 single read
    lat = 2; a = 16'h1234;
    hwrite(A_CMD, mk(1, 1, 0, 0, a));
    check(ireq && !iwe && iaddr == a, "R2", "read request", {ireq, iwe, 14'h0, iaddr}, {2'b10, 14'h0, a});
    hread(A_CMD, v);  check(v[31] == 1'b1, "R3", "busy during access", v, 32'h8000_0000 | v);
    wait_idle("R3");
    hread(A_DATA, v); check(v == model_rd(a), "R4", "single read data", v, model_rd(a));
    rc = r_cnt;
    hread(A_DATA, v); repeat (4) @(negedge clk);
    check(r_cnt == rc && !ireq, "R4", "non-stream data read starts nothing", 32'(r_cnt), 32'(rc));

    // R5 single write
    wc = w_cnt; d = 32'hCAFE_0005; a = 16'h0777;
    hwrite(A_DATA, d);
    hwrite(A_CMD, mk(1, 0, 0, 0, a));
    check(ireq && iwe && iaddr == a && iwdata == d, "R5", "write request", iwdata, d);
    wait_idle("R5");
    check(w_cnt == wc + 1 && w_addr == a && w_data == d, "R5", "write landed", {w_addr, 16'h0}, {a, 16'h0});

    // R3/R10 collision: command write on the ack-sampling edge is dropped
    lat = 3; a = 16'h0042;
    hwrite(A_CMD, mk(1, 1, 0, 0, a));
    repeat (3) @(negedge clk);
    hwrite(A_CMD, mk(1, 1, 0, 0, 16'h5555));
    check(!ireq, "R3", "busy clear cycle after ack", 32'(ireq), 32'h0);
    hread(A_CMD, v); check(v[15:0] == a && !v[31], "R10", "cmd write on ack edge dropped", v, mk(0, 1, 0, 0, a));
    hread(A_STAT, v); check(v == 32'h1, "R10", "error flag set", v, 32'h1);
    hwrite(A_STAT, 32'h1);
    hread(A_STAT, v); check(v == 32'h0, "R10", "error flag cleared", v, 32'h0);

    // R10 data write while busy dropped
    lat = 4; d = 32'h1111_2222;
    hwrite(A_DATA, d);
    hwrite(A_CMD, mk(1, 0, 0, 0, 16'h0009));
    hwrite(A_DATA, 32'hDEAD_BEEF);
    wait_idle("R10");
    hread(A_DATA, v); check(v == d, "R10", "data write while busy dropped", v, d);
    hread(A_STAT, v); check(v == 32'h1, "R10", "error after data drop", v, 32'h1);
    hwrite(A_STAT, 32'h1);

    // R6/R8 streaming reads: up with wrap, down with wrap, both flags
    for (int mode = 0; mode < 3; mode++) begin
      bit inc = (mode != 1), dec = (mode != 0);
      lat = mode;
      cur = (mode == 0) ? 16'hFFFE : (mode == 1) ? 16'h0001 : 16'h0010;
      hwrite(A_CMD, mk(1, 1, inc, dec, cur));
      wait_idle("R6");
      for (int i = 0; i < 2; i++) begin
        hread(A_DATA, v); check(v == model_rd(cur), "R6", "stream read data", v, model_rd(cur));
        cur = step(cur, inc, dec);
        wait_idle("R6");
        hread(A_CMD, v); check(v[15:0] == cur, "R8", "stepped address", v, {16'h0, cur});
      end
      hwrite(A_CMD, mk(0, 1, 0, 0, cur));
      rc = r_cnt;
      hread(A_DATA, v); check(v == model_rd(cur), "R6", "last stream word", v, model_rd(cur));
      repeat (4) @(negedge clk);
      check(r_cnt == rc && !ireq, "R6", "no read after flags cleared", 32'(r_cnt), 32'(rc));
    end

    // R6 data read while busy does not advance the stream
    lat = 5; cur = 16'h0200;
    hwrite(A_CMD, mk(1, 1, 1, 0, cur));
    hread(A_DATA, v);
    wait_idle("R6");
    hread(A_CMD, v); check(v[15:0] == cur, "R6", "read while busy no step", v, {16'h0, cur});
    hwrite(A_CMD, mk(0, 1, 0, 0, cur));

    // R7 streaming writes, down
    lat = 1; a = 16'h0100;
    hwrite(A_DATA, 32'hA0A0_0001);
    hwrite(A_CMD, mk(1, 0, 0, 1, a));
    wait_idle("R7");
    check(w_addr == a && w_data == 32'hA0A0_0001, "R7", "first stream write", {w_addr, 16'h0}, {a, 16'h0});
    hwrite(A_DATA, 32'hA0A0_0002);
    check(ireq && iwe && iaddr == a - 16'd1, "R7", "stream write request", {16'h0, iaddr}, {16'h0, a - 16'd1});
    wait_idle("R7");
    check(w_addr == a - 16'd1 && w_data == 32'hA0A0_0002, "R7", "second stream write", w_data, 32'hA0A0_0002);

    // R11/R12 command update without start, reserved bits
    wc = w_cnt; rc = r_cnt;
    hwrite(A_CMD, 32'h7FFF_BEEF);
    repeat (3) @(negedge clk);
    check(!ireq && w_cnt == wc && r_cnt == rc, "R12", "no access without start", 32'(ireq), 0);
    hread(A_CMD, v); check(v == 32'h7000_BEEF, "R11", "reserved bits zero", v, 32'h7000_BEEF);
    hwrite(A_CMD, 32'h0000_0000);

    // R9 direct window write
    lat = 2; d = 32'h9999_0042;
    hwrite(8'h80 | 8'h2A, d);
    check(ireq && iwe && iaddr == WBASE + 16'h2A, "R9", "window request", {16'h0, iaddr}, {16'h0, WBASE + 16'h2A});
    wait_idle("R9");
    check(w_addr == WBASE + 16'h2A && w_data == d, "R9", "window write landed", w_data, d);
    hread(A_CMD, v); check(v == 32'h0, "R9", "command unchanged by window", v, 32'h0);
    hread(A_DATA, v); check(v == d, "R9", "window loads holding reg", v, d);

    // random mix: single reads, single writes, window writes
    for (int it = 0; it < 40; it++) begin
      int op = $urandom_range(0, 2);
      lat = $urandom_range(0, 4);
      a = 16'($urandom);
      d = $urandom;
      if (op == 0) begin
        hwrite(A_CMD, mk(1, 1, 0, 0, a)); wait_idle("R4");
        hread(A_DATA, v); check(v == model_rd(a), "R4", "random read", v, model_rd(a));
      end else if (op == 1) begin
        hwrite(A_DATA, d); hwrite(A_CMD, mk(1, 0, 0, 0, a)); wait_idle("R5");
        check(w_addr == a && w_data == d, "R5", "random write", w_data, d);
      end else begin
        logic [6:0] off = 7'($urandom);
        hwrite({1'b1, off}, d); wait_idle("R9");
        check(w_addr == WBASE + 16'(off) && w_data == d, "R9", "random window", {w_addr, 16'h0}, {WBASE + 16'(off), 16'h0});
      end
    end
    hread(A_STAT, v); check(v == 32'h0, "R10", "no error in legal traffic", v, 32'h0);

    finish_run();
  end
endmodule